// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and offers the processor the single most urgent one. Each source carries an enable bit and a 4-bit priority. A global threshold holds back every source whose priority does not exceed it. One registered interrupt output tells the processor that at least one enabled, asserted source clears the threshold.

Software uses a plain word-addressed register bus with address, write data, write strobe, read strobe and read data. Sources are switched on or off by writing their number to one of two command words, so software never needs a read-modify-write of an enable bitmap. One status read returns the winning source and its priority packed into a word, or all ones when nothing qualifies. The interrupt service loop can stop as soon as the word reads negative.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all enables, all priorities and the threshold are 0, `irq_o` is 0 and the status word reads 0xFFFFFFFF.
- R2: A write of value n to word 0x00 sets the enable of source n only. A value of 64 or more changes nothing; the full 32-bit value is compared, not its low bits.
- R3: A write of value n to word 0x01 clears the enable of source n only. A value of 64 or more changes nothing.
- R4: The priority of source n is held in bits [(n mod 8)*4 +: 4] of word 0x17 - (n div 8), so sources 0-7 are at 0x17 and sources 56-63 at 0x10. Each word reads back what was last written.
- R5: The threshold is held in bits [3:0] of word 0x02 and reads back there. A source can win or raise `irq_o` only if its priority is strictly greater than the threshold.
- R6: Word 0x03 reads {source number in [31:16], priority in [15:0]} of the winner, or 0xFFFFFFFF when no source qualifies.
- R7: The qualifying source with the highest priority wins. Among equal priorities, the higher source number wins.
- R8: Requests are level-sensitive: a source takes part in selection only while its line is high, and the status read reflects the lines in the same cycle.
- R9: `irq_o` rises one clock after a qualifying source appears and falls one clock after the last one is gone or masked.
- R10: Words 0x04 and 0x05 read the enables of sources 0-31 and 32-63. Any other unmapped word, and the write-only words 0x00 and 0x01, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Level request lines, synchronous to clk |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data, 0 when bus_re is low |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions check on every cycle that:
- an in-range enable or disable command flips exactly the named bit and nothing else;
- a priority word holds the last value written;
- the winner is always a qualifying source above the threshold;
- an empty status read is all ones;
- `irq_o` follows the presence of a qualifying source by exactly one clock.

Only the bench scenarios can show the rest:
- the descending placement of the priority words;
- tie breaking toward the higher source number;
- masking at the exact threshold value;
- rejection of out-of-range numbers whose low bits alias a real source;
- the full reset state.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
   localparam int ADR_EN_SET   = 'h00;
   localparam int ADR_EN_CLR   = 'h01;
   localparam int ADR_MASK     = 'h02;
   localparam int ADR_STATUS   = 'h03;
   localparam int ADR_EN_RD    = 'h04;
   localparam int ADR_PRIO_TOP = 'h17;

   typedef struct packed {
      logic [15:0] src;
      logic [15:0] lvl;
   } status_t;
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_req,
   input  logic               clr_req,
   input  logic [DATA_W-1:0]  num,
   output logic [NUM_SRC-1:0] en_o
);
   localparam int IDX_W = $clog2(NUM_SRC);

   logic             in_range;
   logic [IDX_W-1:0] idx;

   assign in_range = num < DATA_W'(NUM_SRC);
   assign idx      = num[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= '0;
      end else if (set_req && in_range) begin
         en_o[idx] <= 1'b1;
      end else if (clr_req && in_range) begin
         en_o[idx] <= 1'b0;
      end
   end

   assert_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && in_range) |=> en_o[$past(idx)]);
   assert_clr_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && in_range && !set_req) |=> !en_o[$past(idx)]);
   assert_single_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(en_o ^ $past(en_o)) <= 1);
   assert_out_of_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |=> $stable(en_o));
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
   parameter int GROUPS = 8,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [GROUPS-1:0]        wr_grp,
   input  logic [DATA_W-1:0]        wdata,
   output logic [GROUPS*DATA_W-1:0] words_o
);
   for (genvar g = 0; g < GROUPS; g++) begin : g_word
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_grp[g]) begin
            word_q <= wdata;
         end
      end

      assign words_o[g*DATA_W +: DATA_W] = word_q;

      assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         wr_grp[g] |=> (word_q == $past(wdata)));
   end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
   parameter int NUM_SRC  = 64,
   parameter int PRIO_W   = 4,
   parameter bit TIE_HIGH = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          qual,
   input  logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
   output logic                        found,
   output logic [$clog2(NUM_SRC)-1:0]  win_idx,
   output logic [PRIO_W-1:0]           win_prio
);
   localparam int IDX_W = $clog2(NUM_SRC);

   if (TIE_HIGH) begin : g_tie_high
      always_comb begin
         found    = 1'b0;
         win_idx  = '0;
         win_prio = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio)) begin
               found    = 1'b1;
               win_idx  = IDX_W'(i);
               win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
         end
      end
   end else begin : g_tie_low
      always_comb begin
         found    = 1'b0;
         win_idx  = '0;
         win_prio = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
               found    = 1'b1;
               win_idx  = IDX_W'(i);
               win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
         end
      end
   end

   assert_win_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> qual[win_idx]);
   assert_none_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (qual == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vector_pkg::*;
#(
   parameter int NUM_SRC  = 64,
   parameter int PRIO_W   = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter bit TIE_HIGH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_we,
   input  logic               bus_re,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);
   localparam int PER_WORD = DATA_W / PRIO_W;
   localparam int GROUPS   = NUM_SRC / PER_WORD;
   localparam int EN_WORDS = NUM_SRC / DATA_W;
   localparam int IDX_W    = $clog2(NUM_SRC);

   if (NUM_SRC % PER_WORD != 0 || NUM_SRC % DATA_W != 0) begin : g_bad_count
      $error("source count must fill whole priority and enable words");
   end
   if (DATA_W != $bits(status_t) || NUM_SRC > 65536) begin : g_bad_status
      $error("status word layout needs 32-bit data and at most 65536 sources");
   end
   if (ADR_PRIO_TOP - GROUPS + 1 < ADR_EN_RD + EN_WORDS) begin : g_bad_map
      $error("priority words overlap enable readback words");
   end

   logic                     hit_set, hit_clr, hit_mask;
   logic [GROUPS-1:0]        hit_prio;
   logic [NUM_SRC-1:0]       en_q;
   logic [GROUPS*DATA_W-1:0] prio_words;
   logic [PRIO_W-1:0]        mask_q;
   logic [NUM_SRC-1:0]       qual;
   logic                     found;
   logic [IDX_W-1:0]         win_idx;
   logic [PRIO_W-1:0]        win_prio;
   status_t                  stat;

   assign hit_set  = bus_we && (bus_addr == ADDR_W'(ADR_EN_SET));
   assign hit_clr  = bus_we && (bus_addr == ADDR_W'(ADR_EN_CLR));
   assign hit_mask = bus_we && (bus_addr == ADDR_W'(ADR_MASK));

   for (genvar g = 0; g < GROUPS; g++) begin : g_prio_dec
      assign hit_prio[g] = bus_we && (bus_addr == ADDR_W'(ADR_PRIO_TOP - g));
   end

   irq_enable_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_enable (
      .clk(clk), .rst_n(rst_n), .set_req(hit_set), .clr_req(hit_clr),
      .num(bus_wdata), .en_o(en_q)
   );

   irq_prio_bank #(.GROUPS(GROUPS), .DATA_W(DATA_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .wr_grp(hit_prio), .wdata(bus_wdata),
      .words_o(prio_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (hit_mask) begin
         mask_q <= bus_wdata[PRIO_W-1:0];
      end
   end

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_qual
      assign qual[n] = irq_lines[n] && en_q[n] &&
                       (prio_words[n*PRIO_W +: PRIO_W] > mask_q);
   end

   irq_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .TIE_HIGH(TIE_HIGH)) u_select (
      .clk(clk), .rst_n(rst_n), .qual(qual), .prio_flat(prio_words),
      .found(found), .win_idx(win_idx), .win_prio(win_prio)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else begin
         irq_o <= found;
      end
   end

   always_comb begin
      if (found) begin
         stat.src = 16'(win_idx);
         stat.lvl = 16'(win_prio);
      end else begin
         stat = '1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (bus_addr == ADDR_W'(ADR_MASK)) begin
            bus_rdata = DATA_W'(mask_q);
         end
         if (bus_addr == ADDR_W'(ADR_STATUS)) begin
            bus_rdata = stat;
         end
         for (int k = 0; k < EN_WORDS; k++) begin
            if (bus_addr == ADDR_W'(ADR_EN_RD + k)) begin
               bus_rdata = en_q[k*DATA_W +: DATA_W];
            end
         end
         for (int g = 0; g < GROUPS; g++) begin
            if (bus_addr == ADDR_W'(ADR_PRIO_TOP - g)) begin
               bus_rdata = prio_words[g*DATA_W +: DATA_W];
            end
         end
      end
   end

   assert_win_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (win_prio > mask_q));
   assert_empty_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == ADDR_W'(ADR_STATUS) && !found) |-> (bus_rdata == '1));
   assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      found |=> irq_o);
   assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !found |=> !irq_o);
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LN = 2'd2, OP_IRQ = 2'd3;
   localparam logic [31:0] NONE = 32'hFFFF_FFFF;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  addr;
      logic [63:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t TBL [NV] = '{
      '{OP_WR, 8'h00, 64'd5,          32'h0,        4'd2},
      '{OP_WR, 8'h00, 64'd40,         32'h0,        4'd2},
      '{OP_WR, 8'h17, 64'h0030_0000,  32'h0,        4'd4},
      '{OP_WR, 8'h12, 64'h3,          32'h0,        4'd4},
      '{OP_RD, 8'h04, 64'd0,          32'h20,       4'd2},  // R2 source 5
      '{OP_RD, 8'h05, 64'd0,          32'h100,      4'd2},  // R2 source 40
      '{OP_RD, 8'h17, 64'd0,          32'h0030_0000,4'd4},  // R4 word order
      '{OP_RD, 8'h12, 64'd0,          32'h3,        4'd4},
      '{OP_RD, 8'h03, 64'd0,          NONE,         4'd6},  // R6 empty
      '{OP_LN, 8'h00, 64'h20,         32'h0,        4'd8},
      '{OP_RD, 8'h03, 64'd0,          32'h0005_0003,4'd6},
      '{OP_IRQ,8'h00, 64'd0,          32'h1,        4'd9},  // R9 rise
      '{OP_LN, 8'h00, 64'h100_0000_0020, 32'h0,     4'd8},
      '{OP_RD, 8'h03, 64'd0,          32'h0028_0003,4'd7},  // R7 tie -> 40
      '{OP_WR, 8'h17, 64'h0090_0000,  32'h0,        4'd4},
      '{OP_RD, 8'h03, 64'd0,          32'h0005_0009,4'd7},  // R7 priority
      '{OP_WR, 8'h02, 64'd9,          32'h0,        4'd5},
      '{OP_RD, 8'h03, 64'd0,          NONE,         4'd5},  // R5 equal masked
      '{OP_IRQ,8'h00, 64'd0,          32'h0,        4'd9},
      '{OP_WR, 8'h02, 64'd8,          32'h0,        4'd5},
      '{OP_RD, 8'h03, 64'd0,          32'h0005_0009,4'd5},
      '{OP_RD, 8'h02, 64'd0,          32'h8,        4'd5},
      '{OP_WR, 8'h02, 64'd2,          32'h0,        4'd5},
      '{OP_WR, 8'h01, 64'd5,          32'h0,        4'd3},
      '{OP_RD, 8'h03, 64'd0,          32'h0028_0003,4'd3},  // R3
      '{OP_RD, 8'h04, 64'd0,          32'h0,        4'd3},
      '{OP_RD, 8'h05, 64'd0,          32'h100,      4'd3},
      '{OP_WR, 8'h00, 64'd64,         32'h0,        4'd2},
      '{OP_WR, 8'h01, 64'd104,        32'h0,        4'd3},
      '{OP_RD, 8'h04, 64'd0,          32'h0,        4'd2},  // R2 64 ignored
      '{OP_RD, 8'h05, 64'd0,          32'h100,      4'd3},  // R3 104 ignored
      '{OP_LN, 8'h00, 64'd0,          32'h0,        4'd8},
      '{OP_RD, 8'h03, 64'd0,          NONE,         4'd8},  // R8 level drop
      '{OP_IRQ,8'h00, 64'd0,          32'h0,        4'd9},
      '{OP_RD, 8'h20, 64'd0,          32'h0,        4'd10}, // R10 unmapped
      '{OP_RD, 8'h00, 64'd0,          32'h0,        4'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_lines = '0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input vec_t v);
      @(negedge clk);
      bus_we = 1'b0;
      bus_re = 1'b0;
      case (v.op)
         OP_WR: begin bus_addr = v.addr; bus_wdata = v.data[31:0]; bus_we = 1'b1; end
         OP_RD: begin bus_addr = v.addr; bus_re = 1'b1; #1 check(int'(v.req), bus_rdata, v.exp); end
         OP_LN: irq_lines = v.data;
         default: check(int'(v.req), 32'(irq_o), v.exp);
      endcase
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      check(1, 32'(irq_o), 32'h0);
      step('{OP_RD, 8'h03, 64'd0, NONE, 4'd1});
      step('{OP_RD, 8'h04, 64'd0, 32'h0, 4'd1});
      step('{OP_RD, 8'h02, 64'd0, 32'h0, 4'd1});
      step('{OP_RD, 8'h17, 64'd0, 32'h0, 4'd1});
      for (int i = 0; i < NV; i++) step(TBL[i]);
      // R7 tie between the extreme sources 0 and 63
      step('{OP_WR, 8'h00, 64'd0,          32'h0, 4'd7});
      step('{OP_WR, 8'h00, 64'd63,         32'h0, 4'd7});
      step('{OP_WR, 8'h17, 64'h0000_000F,  32'h0, 4'd4});
      step('{OP_WR, 8'h10, 64'hF000_0000,  32'h0, 4'd4});
      step('{OP_LN, 8'h00, 64'h8000_0000_0000_0001, 32'h0, 4'd8});
      step('{OP_RD, 8'h03, 64'd0, 32'h003F_000F, 4'd7});
      step('{OP_LN, 8'h00, 64'h1, 32'h0, 4'd8});
      step('{OP_RD, 8'h03, 64'd0, 32'h0000_000F, 4'd8});
      // R5 threshold at the top level masks everything
      step('{OP_WR, 8'h02, 64'd15, 32'h0, 4'd5});
      step('{OP_RD, 8'h03, 64'd0, NONE, 4'd5});
      step('{OP_IRQ, 8'h00, 64'd0, 32'h0, 4'd9});
      step('{OP_RD, 8'h10, 64'd0, 32'hF000_0000, 4'd4});
      // R1 reset in mid-run clears the stored state
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      step('{OP_RD, 8'h04, 64'd0, 32'h0, 4'd1});
      step('{OP_RD, 8'h10, 64'd0, 32'h0, 4'd1});
      step('{OP_RD, 8'h02, 64'd0, 32'h0, 4'd1});
      step('{OP_RD, 8'h03, 64'd0, NONE, 4'd1});
      step('{OP_IRQ, 8'h00, 64'd0, 32'h0, 4'd1});
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule